// File: doc/BRIEF.md
# Multi-Hart Real-Time Timer

This block keeps one 64-bit time counter for a cluster of harts. It also holds a 64-bit compare word for each hart. The counter advances by one on every clock in which the timebase tick input is high. Each hart has its own level interrupt line. That line is high while the hart's compare word is at or below the counter value, using an unsigned comparison.

Software reaches the counter and the compare words through a small register bus. The bus accepts one request per cycle and carries either a 4-byte or an 8-byte access. The compare words sit in consecutive 8-byte slots starting at a compare base offset, one slot per hart. The counter sits in one 8-byte slot at a time base offset. A 4-byte access reaches one half of a word and leaves the other half as it was, so 32-bit software can build a 64-bit value in two steps. A read request is answered with a registered response on the following cycle.

Top module: `rt_timer_unit`

## Requirements
- R1: While reset is held, and on release, the counter reads zero, every interrupt line is low, every compare word reads all ones and no response is valid.
- R2: The counter increases by exactly one in each cycle where tick is high and no write to the counter takes place; otherwise it holds its value.
- R3: A write to the counter that lands in the same cycle as a tick stores the written value, and that cycle adds no increment.
- R4: Hart i's compare word sits at compare base + 8·i, with the low half at +0 and the high half at +4. A 4-byte read at +0 returns bits 31:0 in rdata[31:0] with the upper 32 bits zero. An 8-byte read at +0 returns all 64 bits. A read at +4 of either size returns bits 63:32 in rdata[31:0]. The counter uses the same layout at the time base.
- R5: A 4-byte write at +0 replaces bits 31:0 and keeps bits 63:32. A 4-byte write at +4 replaces bits 63:32 and keeps bits 31:0. Only wdata[31:0] is used. This holds for compare words and for the counter.
- R6: An 8-byte write to a +4 offset changes nothing, for both the compare words and the counter.
- R7: irq[i] goes high when compare[i] ≤ counter (unsigned) and low otherwise. The line updates one cycle after the registers take their new values. Writing a compare word in the past raises the line, and writing one in the future drops it.
- R8: A write to the counter re-evaluates every hart's interrupt line in the same cycle.
- R9: An unmapped request has no effect on writes and returns zero on reads. This covers a compare slot index at or above NHARTS, an address with bits 1:0 non-zero, and any offset outside both regions.
- R10: rsp_valid is high for exactly the cycle after each read request. The data reflects the register values from before that cycle's update.
- R11: The counter wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; counter advances when high |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | ADDR_W | Byte offset inside the block |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 64 | Read data |
| irq | output | NHARTS | Per-hart level timer interrupt |

## Verification
The hardest case to reach from the ports is a single counter write that moves several harts' interrupt lines at once, in different directions. A further difficulty is an equality match that only exists after two half writes have been merged. The stimulus first places compare words on both sides of a planned counter value. It then writes the counter whole and afterwards in halves, so that each step crosses a different set of compare words. Its final step lands exactly on one compare word built from two 4-byte writes. A later full write moves the counter backwards and drops most of the lines together.

// File: rtl/rt_timer_pkg.sv
package rt_timer_pkg;

  // Kind of update a bus write applies to a 64-bit word.
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_FULL = 2'd1,
    WR_LOW  = 2'd2,
    WR_HIGH = 2'd3
  } wr_kind_e;

  function automatic logic [63:0] merge_word(input logic [63:0] old_v,
                                             input logic [63:0] wd,
                                             input wr_kind_e    kind);
    logic [63:0] res;
    case (kind)
      WR_FULL: res = wd;
      WR_LOW:  res = {old_v[63:32], wd[31:0]};
      WR_HIGH: res = {wd[31:0], old_v[31:0]};
      default: res = old_v;
    endcase
    return res;
  endfunction

  function automatic logic [63:0] read_view(input logic [63:0] v,
                                            input logic        upper,
                                            input logic        wide);
    logic [63:0] res;
    if (upper)     res = {32'd0, v[63:32]};
    else if (wide) res = v;
    else           res = {32'd0, v[31:0]};
    return res;
  endfunction

endpackage

// File: rtl/rt_decode.sv
module rt_decode
  import rt_timer_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NHARTS    = 4,
  parameter int CMP_BASE  = 'h000,
  parameter int TIME_BASE = 'h100,
  parameter int IDXW      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              time_hit,
  output logic              cmp_hit,
  output logic [IDXW-1:0]   cmp_idx,
  output logic              upper,
  output wr_kind_e          kind
);
  localparam logic [ADDR_W-1:0] CMP_LO  = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] CMP_HI  = ADDR_W'(CMP_BASE + 8 * NHARTS);
  localparam logic [ADDR_W-1:0] TIME_LO = ADDR_W'(TIME_BASE);

  logic aligned;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    upper    = addr[2];
    time_hit = aligned && (addr[ADDR_W-1:3] == TIME_LO[ADDR_W-1:3]);
    cmp_hit  = aligned && (addr >= CMP_LO) && (addr < CMP_HI);
    cmp_idx  = IDXW'((addr - CMP_LO) >> 3);
    if (wide) kind = upper ? WR_NONE : WR_FULL;
    else      kind = upper ? WR_HIGH : WR_LOW;
  end
endmodule

// File: rtl/rt_time_count.sv
module rt_time_count
  import rt_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  wr_kind_e    wr_kind,
  input  logic [63:0] wdata,
  output logic [63:0] time_q
);
  logic [63:0] time_d;
  logic        time_ce;

  always_comb begin
    time_ce = wr_en | tick;
    time_d  = time_q;
    if (wr_en)     time_d = merge_word(time_q, wdata, wr_kind);
    else if (tick) time_d = time_q + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_ce) time_q <= time_d;
  end
endmodule

// File: rtl/rt_cmp_slot.sv
module rt_cmp_slot
  import rt_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  wr_kind_e    wr_kind,
  input  logic [63:0] wdata,
  input  logic [63:0] now,
  output logic [63:0] cmp_q,
  output logic        irq
);
  logic [63:0] cmp_d;
  logic        hit_d;

  always_comb begin
    cmp_d = merge_word(cmp_q, wdata, wr_kind);
    hit_d = (cmp_q <= now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmp_q <= '1;
    else if (wr_en) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit_d;
  end
endmodule

// File: rtl/rt_timer_unit.sv
module rt_timer_unit
  import rt_timer_pkg::*;
#(
  parameter int NHARTS    = 4,
  parameter int ADDR_W    = 12,
  parameter int CMP_BASE  = 'h000,
  parameter int TIME_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [NHARTS-1:0] irq
);
  localparam int IDXW = (NHARTS > 1) ? $clog2(NHARTS) : 1;

  logic            time_hit;
  logic            cmp_hit;
  logic [IDXW-1:0] cmp_idx;
  logic            upper;
  wr_kind_e        kind;
  logic            wr_ok;
  logic            rd_fire;
  logic            time_wr;
  logic [63:0]     time_q;
  logic [63:0]     cmp_val [NHARTS];
  logic [63:0]     rd_d;

  rt_decode #(
    .ADDR_W(ADDR_W), .NHARTS(NHARTS), .CMP_BASE(CMP_BASE),
    .TIME_BASE(TIME_BASE), .IDXW(IDXW)
  ) u_dec (
    .addr(req_addr), .wide(req_wide), .time_hit(time_hit),
    .cmp_hit(cmp_hit), .cmp_idx(cmp_idx), .upper(upper), .kind(kind)
  );

  always_comb begin
    wr_ok   = req_valid && req_write && (kind != WR_NONE);
    rd_fire = req_valid && !req_write;
    time_wr = wr_ok && time_hit;
  end

  rt_time_count u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(time_wr),
    .wr_kind(kind), .wdata(req_wdata), .time_q(time_q)
  );

  for (genvar i = 0; i < NHARTS; i++) begin : g_slot
    logic slot_wr;
    assign slot_wr = wr_ok && cmp_hit && (cmp_idx == IDXW'(i));
    rt_cmp_slot u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(slot_wr), .wr_kind(kind),
      .wdata(req_wdata), .now(time_q), .cmp_q(cmp_val[i]), .irq(irq[i])
    );
  end

  always_comb begin
    rd_d = '0;
    if (time_hit)     rd_d = read_view(time_q, upper, req_wide);
    else if (cmp_hit) rd_d = read_view(cmp_val[cmp_idx], upper, req_wide);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (rd_fire) rsp_rdata <= rd_d;
  end
endmodule

// File: rtl/rt_timer_chk.sv
module rt_timer_chk #(
  parameter int NHARTS = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_wide,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic [NHARTS-1:0] irq,
  input logic [63:0]       time_q,
  input logic              time_hit,
  input logic              cmp_hit
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (time_q == 64'd0 && irq == '0 && !rsp_valid));

  // R2
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(req_valid && req_write && time_hit)) |=> time_q == $past(time_q) + 64'd1);

  // R2
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(req_valid && req_write && time_hit)) |=> $stable(time_q));

  // R6
  wide_high_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wide && req_addr[2] && time_hit && !tick) |=> $stable(time_q));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick || (req_valid && req_write), 2) |-> $stable(irq));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !time_hit && !cmp_hit) |=> rsp_rdata == 64'd0);

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R10
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind rt_timer_unit rt_timer_chk #(.NHARTS(NHARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
  .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq),
  .time_q(time_q), .time_hit(time_hit), .cmp_hit(cmp_hit)
);

// File: tb/rt_timer_unit_test.sv
`timescale 1ns/1ps
module rt_timer_unit_test;
  localparam int NH = 4;
  localparam int AW = 12;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_wide = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic [NH-1:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  rt_timer_unit #(.NHARTS(NH), .ADDR_W(AW), .CMP_BASE('h000), .TIME_BASE('h100)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic wide, input logic [63:0] d,
                    input logic tk = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = wide; req_addr = a; req_wdata = d; tick = tk;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic wide, input logic [63:0] exp,
                    input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = a; req_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic irq_is(input logic [NH-1:0] exp, input string tag);
    @(negedge clk);
    chk(tag, 64'(irq), 64'(exp));
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 64'd1, 64'd0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 64'(irq), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 64'(irq), 64'd0);
    chk("R10 rsp_valid idle", 64'(rsp_valid), 64'd0);
    rd('h100, 1'b1, 64'd0, "R1 counter zero");
    rd('h000, 1'b1, ONES, "R1 compare all ones");
    rd('h018, 1'b1, ONES, "R1 compare3 all ones");

    // R4 layout, R5 merging
    wr('h008, 1'b1, 64'h1111_2222_3333_4444);
    rd('h008, 1'b0, 64'h0000_0000_3333_4444, "R4 low half read");
    rd('h00C, 1'b0, 64'h0000_0000_1111_2222, "R4 high half read");
    rd('h00C, 1'b1, 64'h0000_0000_1111_2222, "R4 wide read at +4");
    rd('h008, 1'b1, 64'h1111_2222_3333_4444, "R4 full read");
    wr('h008, 1'b0, 64'hDEAD_BEEF_AAAA_BBBB);
    rd('h008, 1'b1, 64'h1111_2222_AAAA_BBBB, "R5 low merge");
    wr('h00C, 1'b0, 64'hDEAD_BEEF_5555_6666);
    rd('h008, 1'b1, 64'h5555_6666_AAAA_BBBB, "R5 high merge");

    // R6 wide write to +4 ignored
    wr('h00C, 1'b1, 64'd0);
    rd('h008, 1'b1, 64'h5555_6666_AAAA_BBBB, "R6 compare unchanged");
    wr('h104, 1'b1, 64'h0000_0000_0000_0077);
    rd('h100, 1'b1, 64'd0, "R6 counter unchanged");

    // R9 unmapped
    rd('h020, 1'b1, 64'd0, "R9 slot beyond harts reads zero");
    rd('h002, 1'b1, 64'd0, "R9 misaligned reads zero");
    rd('h200, 1'b1, 64'd0, "R9 outside reads zero");
    wr('h020, 1'b1, 64'd0);
    wr('h002, 1'b1, 64'd0);
    wr('h800, 1'b1, 64'd0);
    rd('h000, 1'b1, ONES, "R9 compare0 untouched");
    rd('h010, 1'b1, ONES, "R9 compare2 untouched");
    rd('h018, 1'b1, ONES, "R9 compare3 untouched");
    rd('h100, 1'b1, 64'd0, "R9 counter untouched");
    irq_is(4'b0000, "R9 irq untouched");

    // R7 compare writes
    wr('h010, 1'b1, 64'd0);
    irq_is(4'b0100, "R7 equal raises");
    wr('h010, 1'b1, 64'd1);
    irq_is(4'b0000, "R7 future drops");
    wr('h000, 1'b1, 64'd50);
    wr('h018, 1'b1, 64'd80);
    irq_is(4'b0000, "R7 all future");

    // R8 counter writes re-evaluate all harts
    wr('h100, 1'b1, 64'd60);
    irq_is(4'b0101, "R8 full counter write");
    wr('h104, 1'b0, 64'h0000_0000_5555_6666);
    irq_is(4'b1101, "R8 high half counter write");
    wr('h100, 1'b0, 64'h0000_0000_AAAA_BBBB);
    irq_is(4'b1111, "R8 equality after merge");
    rd('h100, 1'b1, 64'h5555_6666_AAAA_BBBB, "R5 counter merge");
    wr('h100, 1'b1, 64'd5);
    irq_is(4'b0100, "R8 counter moved back");

    // R2 ticking
    wr('h100, 1'b1, 64'd100);
    ticks(7);
    rd('h100, 1'b1, 64'd107, "R2 seven ticks");
    repeat (3) @(negedge clk);
    rd('h100, 1'b1, 64'd107, "R2 hold without tick");

    // R3 write beats tick
    wr('h100, 1'b1, 64'd500, 1'b1);
    rd('h100, 1'b1, 64'd500, "R3 write wins over tick");

    // R11 wrap
    wr('h100, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
    ticks(3);
    rd('h100, 1'b1, 64'd1, "R11 wrap to zero");

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule